// File: doc/BRIEF.md
# Processor Interrupt Level Priority Resolver

This block decides which interrupt level, if any, a processor core should be asked to take. It merges two request sources into one pending vector: external level requests arriving on a 16-bit line, and a soft-interrupt register. It compares that vector with the core's current mask level. It then picks the highest level that clears the mask and drives a registered request with a trap-type index.

Two timer flags in the soft-interrupt register do not stand for levels of their own. Either flag makes level 14 pending. Three conditions stop a new request from being raised. A vector interrupt may be in service. A more urgent external-level trap may already be active at a nonzero trap level. The chosen trap type may equal the one already latched. A mask level that blocks everything, or a global disable, withdraws the request.

Top module: `irq_lvl_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_req` goes to 0 and `trap_idx` goes to 0 at that edge.
- R2: Bits 1 to 15 of `soft_int` request the level of the same number, in the same way as the matching bit of `ext_lvl`. Bit 0 (tick timer) and bit 16 (system-tick timer) of `soft_int` do not request a level of their own number.
- R3: When bit 0 or bit 16 of `soft_int` is set, level 14 is pending.
- R4: While `vec_busy` is high, `irq_req` and `trap_idx` keep their values at the next edge, whatever the other inputs do.
- R5: When the pending vector, read as an unsigned number, is below 2 shifted left by `mask_lvl`, the next edge clears `irq_req` and `trap_idx`. With a mask of 15, nothing can be raised. A pending level equal to the mask level is not taken.
- R6: Otherwise, with `int_en` high, the highest pending level L above `mask_lvl` is chosen. The trap type is 0x040 OR L, with L in bits 3:0. `irq_req` goes to 1 with that value in `trap_idx`.
- R7: The raise of R6 is withheld, and the outputs hold, when three things are all true: `trap_lvl` is nonzero, `cur_tt` bits 8:4 equal 4 (the external-level group), and `cur_tt` is greater than the new trap type.
- R8: The raise of R6 goes ahead in three cases: `trap_lvl` is zero, `cur_tt` lies outside the group, or `cur_tt` is not greater than the new trap type.
- R9: When `int_en` is low and R4 and R5 do not apply, the next edge clears `irq_req` and `trap_idx`.
- R10: The outputs are registered. A change on any input shows on `irq_req` and `trap_idx` only after the next rising edge. Holding the same inputs leaves the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External pending levels, bit n is level n |
| soft_int | input | 17 | Soft-interrupt register; bit 0 tick timer, bit 16 system-tick timer, bits 1 to 15 levels |
| mask_lvl | input | 4 | Current processor interrupt mask level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type currently being serviced |
| vec_busy | input | 1 | A vector interrupt is in service |
| irq_req | output | 1 | Hard-interrupt request |
| trap_idx | output | 9 | Selected trap type, zero when there is no request |

## Verification
The main function is tried with several patterns. One has a single external level above the mask. One has several levels at once, where the highest must win over the lower ones. One has soft-register levels alone, where a level bit must behave like an external one. One has each timer flag alone, which must resolve to level 14 rather than levels 0 or 16. Boundary patterns place a pending level exactly at the mask and exactly one above it, and use mask 15, to separate the strict comparison from an inclusive one. Trap-level patterns vary three things one at a time: the trap level being zero or not, the active trap type being inside or outside the external group, and the active trap type being above or below the new one. This shows that only the three conditions together block a raise.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    localparam int LVL_N     = 16;
    localparam int LVL_W     = $clog2(LVL_N);
    localparam int SOFT_W    = LVL_N + 1;
    localparam int TT_W      = 9;
    localparam int TL_W      = 3;
    localparam int TICK_POS  = 0;
    localparam int STICK_POS = 16;
    localparam int TIMER_LVL = 14;
    localparam int GRP_LSB   = 4;
    localparam logic [TT_W-1:0] EXT_BASE = 9'h040;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_RAISE = 2'd2
    } act_e;

    typedef struct packed {
        logic            req;
        logic [TT_W-1:0] tt;
    } irq_out_t;

    function automatic logic in_ext_group(input logic [TT_W-1:0] tt);
        return tt[TT_W-1:GRP_LSB] == EXT_BASE[TT_W-1:GRP_LSB];
    endfunction
endpackage

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge
    import irq_lvl_pkg::*;
#(
    parameter int N_LVL   = LVL_N,
    parameter int N_SOFT  = SOFT_W,
    parameter int P_TICK  = TICK_POS,
    parameter int P_STICK = STICK_POS,
    parameter int P_TLVL  = TIMER_LVL
) (
    input  logic [N_LVL-1:0]  ext_lvl,
    input  logic [N_SOFT-1:0] soft_int,
    output logic [N_LVL-1:0]  pend
);
    logic timer_hit;
    logic [N_LVL-1:0] base;

    assign timer_hit = soft_int[P_TICK] | soft_int[P_STICK];

    for (genvar g = 0; g < N_LVL; g++) begin : g_bit
        if (g == P_TICK || g == P_STICK) begin : g_timer
            assign base[g] = ext_lvl[g];
        end else begin : g_level
            assign base[g] = ext_lvl[g] | soft_int[g];
        end
    end

    assign pend = base | (N_LVL'(timer_hit) << P_TLVL);
endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
    import irq_lvl_pkg::*;
#(
    parameter int N_LVL = LVL_N,
    parameter int W_LVL = LVL_W
) (
    input  logic [N_LVL-1:0] pend,
    input  logic [W_LVL-1:0] mask_lvl,
    output logic             below,
    output logic             hit_valid,
    output logic [W_LVL-1:0] hit_lvl
);
    localparam int CMP_W = N_LVL + 1;

    logic [CMP_W-1:0] thr;

    assign thr   = CMP_W'(2) << mask_lvl;
    assign below = {1'b0, pend} < thr;

    always_comb begin
        hit_valid = 1'b0;
        hit_lvl   = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (pend[i] && (i > int'(mask_lvl))) begin
                hit_valid = 1'b1;
                hit_lvl   = W_LVL'(i);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int W_LVL = LVL_W,
    parameter int W_TT  = TT_W,
    parameter int W_TL  = TL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             below,
    input  logic             hit_valid,
    input  logic [W_LVL-1:0] hit_lvl,
    input  logic             int_en,
    input  logic [W_TL-1:0]  trap_lvl,
    input  logic [W_TT-1:0]  cur_tt,
    input  logic             vec_busy,
    output irq_out_t         q
);
    logic [W_TT-1:0] new_tt;
    logic            blocked;
    act_e            act;

    assign new_tt  = EXT_BASE | W_TT'(hit_lvl);
    assign blocked = (trap_lvl != '0) && in_ext_group(cur_tt) && (cur_tt > new_tt);

    always_comb begin
        if (vec_busy)
            act = ACT_HOLD;
        else if (below || !int_en)
            act = ACT_CLEAR;
        else if (!hit_valid || blocked || (q.tt == new_tt))
            act = ACT_HOLD;
        else
            act = ACT_RAISE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (act)
                ACT_CLEAR: q <= '0;
                ACT_RAISE: q <= '{req: 1'b1, tt: new_tt};
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/irq_lvl_resolver.sv
module irq_lvl_resolver
    import irq_lvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_N-1:0]  ext_lvl,
    input  logic [SOFT_W-1:0] soft_int,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic              int_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [TT_W-1:0]   cur_tt,
    input  logic              vec_busy,
    output logic              irq_req,
    output logic [TT_W-1:0]   trap_idx
);
    logic [LVL_N-1:0] pend;
    logic             below;
    logic             hit_valid;
    logic [LVL_W-1:0] hit_lvl;
    irq_out_t         q;

    irq_lvl_merge u_merge (
        .ext_lvl  (ext_lvl),
        .soft_int (soft_int),
        .pend     (pend)
    );

    irq_lvl_pick u_pick (
        .pend      (pend),
        .mask_lvl  (mask_lvl),
        .below     (below),
        .hit_valid (hit_valid),
        .hit_lvl   (hit_lvl)
    );

    irq_lvl_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .below     (below),
        .hit_valid (hit_valid),
        .hit_lvl   (hit_lvl),
        .int_en    (int_en),
        .trap_lvl  (trap_lvl),
        .cur_tt    (cur_tt),
        .vec_busy  (vec_busy),
        .q         (q)
    );

    assign irq_req  = q.req;
    assign trap_idx = q.tt;
endmodule

// File: rtl/irq_lvl_resolver_chk.sv
module irq_lvl_resolver_chk
    import irq_lvl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [LVL_N-1:0]  ext_lvl,
    input logic [SOFT_W-1:0] soft_int,
    input logic [LVL_W-1:0]  mask_lvl,
    input logic              int_en,
    input logic [TL_W-1:0]   trap_lvl,
    input logic [TT_W-1:0]   cur_tt,
    input logic              vec_busy,
    input logic              irq_req,
    input logic [TT_W-1:0]   trap_idx
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_req && trap_idx == '0));

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        vec_busy |=> (irq_req == $past(irq_req) && trap_idx == $past(trap_idx)));

    a_r5_nothing_pending: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && ext_lvl == '0 && soft_int == '0) |=> (!irq_req && trap_idx == '0));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && !int_en) |=> (!irq_req && trap_idx == '0));

    a_r3_timer_level: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && int_en && soft_int[TICK_POS] && mask_lvl < 4'd14 && trap_lvl == '0
         && !ext_lvl[15] && !soft_int[15]) |=> (irq_req && trap_idx == (EXT_BASE | 9'd14)));

    a_r7_top_trap_blocks: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && trap_lvl != '0 && cur_tt == (EXT_BASE | 9'd15) && !irq_req
         && !ext_lvl[15] && !soft_int[15]) |=> !irq_req);

    a_r6_idx_in_group: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (in_ext_group(trap_idx) && trap_idx[GRP_LSB-1:0] != '0));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> trap_idx == '0);
endmodule

bind irq_lvl_resolver irq_lvl_resolver_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_lvl  (ext_lvl),
    .soft_int (soft_int),
    .mask_lvl (mask_lvl),
    .int_en   (int_en),
    .trap_lvl (trap_lvl),
    .cur_tt   (cur_tt),
    .vec_busy (vec_busy),
    .irq_req  (irq_req),
    .trap_idx (trap_idx)
);

// File: tb/irq_lvl_resolver_bench.sv
`timescale 1ns/1ps
module irq_lvl_resolver_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ext_lvl  = '0;
    logic [16:0] soft_int = '0;
    logic [3:0]  mask_lvl = '0;
    logic        int_en   = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  cur_tt   = '0;
    logic        vec_busy = 1'b0;
    logic        irq_req;
    logic [8:0]  trap_idx;

    int n_cmp  = 0;
    int n_fail = 0;

    typedef struct {
        logic       req;
        logic [8:0] tt;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic       m_req = 1'b0;
    logic [8:0] m_tt  = '0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;

    irq_lvl_resolver u_irq_lvl_resolver (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
        .mask_lvl(mask_lvl), .int_en(int_en), .trap_lvl(trap_lvl),
        .cur_tt(cur_tt), .vec_busy(vec_busy), .irq_req(irq_req), .trap_idx(trap_idx)
    );

    task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] m,
                        input logic ie, input logic [2:0] tl, input logic [8:0] ct,
                        input logic vb, input string tag);
        logic [15:0] p;
        int          top;
        logic [8:0]  ntt;
        exp_t        x;
        @(negedge clk);
        ext_lvl = e; soft_int = s; mask_lvl = m; int_en = ie;
        trap_lvl = tl; cur_tt = ct; vec_busy = vb;
        p = e | {s[15:1], 1'b0};
        if (s[0] || s[16]) p[14] = 1'b1;
        if (vb) begin
        end else if ({1'b0, p} < (17'd2 << m) || !ie) begin
            m_req = 1'b0; m_tt = '0;
        end else begin
            top = 0;
            for (int i = 15; i > int'(m); i--) if (p[i] && top == 0) top = i;
            ntt = 9'h040 | 9'(top);
            if (tl != 0 && ct > ntt && ct[8:4] == 5'd4) begin
            end else if (m_tt != ntt) begin
                m_req = 1'b1; m_tt = ntt;
            end
        end
        x.req = m_req; x.tt = m_tt; x.tag = tag;
        sb.push_back(x);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_cmp++;
            if (irq_req !== x.req || trap_idx !== x.tt) begin
                n_fail++;
                $display("FAIL %s: got req=%0b idx=%h, expected req=%0b idx=%h",
                         x.tag, irq_req, trap_idx, x.req, x.tt);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (irq_req !== 1'b0 || trap_idx !== 9'h000) begin
            n_fail++;
            $display("FAIL R1: got req=%0b idx=%h, expected req=0 idx=000", irq_req, trap_idx);
        end
        rst = 1'b0;

        step(16'h0020, '0, 4'd2, 1, 0, 0, 0, "R6 single level");
        step(16'h1208, '0, 4'd4, 1, 0, 0, 0, "R6 highest of several");
        step(16'h1208, '0, 4'd4, 1, 0, 0, 0, "R10 same inputs hold");
        step(16'h0000, 17'h00080, 4'd3, 1, 0, 0, 0, "R2 soft level bit");
        step(16'h0000, 17'h00001, 4'd0, 1, 0, 0, 0, "R3 tick flag");
        step(16'h0000, '0, 4'd0, 1, 0, 0, 0, "R5 clear");
        step(16'h0000, 17'h10000, 4'd0, 1, 0, 0, 0, "R3 stick flag");
        step(16'h8000, 17'h00001, 4'd0, 1, 0, 0, 0, "R3 level 15 above timer");
        step(16'h0008, '0, 4'd3, 1, 0, 0, 0, "R5 level equal mask");
        step(16'h0080, '0, 4'd6, 1, 0, 0, 0, "R6 level one above mask");
        step(16'h8000, '0, 4'd15, 1, 0, 0, 0, "R5 mask 15");
        step(16'h0020, '0, 4'd0, 1, 0, 0, 0, "R6 raise before busy");
        step(16'h0000, '0, 4'd0, 1, 0, 0, 1, "R4 busy with nothing pending");
        step(16'h0200, '0, 4'd0, 0, 0, 0, 1, "R4 busy with new level");
        step(16'h0200, '0, 4'd0, 0, 0, 0, 0, "R9 disabled clears");
        step(16'h0020, '0, 4'd0, 1, 3'd1, 9'h04A, 0, "R7 higher active trap blocks");
        step(16'h0020, '0, 4'd0, 1, 3'd0, 9'h04A, 0, "R8 trap level zero");
        step(16'h0000, '0, 4'd0, 1, 0, 0, 0, "R5 clear");
        step(16'h0020, '0, 4'd0, 1, 3'd2, 9'h060, 0, "R8 active trap outside group");
        step(16'h0000, '0, 4'd0, 1, 0, 0, 0, "R5 clear");
        step(16'h0020, '0, 4'd0, 1, 3'd1, 9'h044, 0, "R8 lower active trap");
        step(16'h8020, '0, 4'd0, 1, 3'd1, 9'h04E, 0, "R7 higher level passes active trap");
        step(16'h0020, 17'h00004, 4'd1, 1, 3'd1, 9'h04F, 0, "R7 lower level blocked");
        step(16'h0000, 17'h0FFFE, 4'd14, 1, 0, 0, 0, "R2 soft bit 15 only");
        step(16'h0000, 17'h10001, 4'd14, 1, 0, 0, 0, "R5 timer at mask 14");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule